// File: doc/BRIEF.md
# Registered Address/Command Fan-out Register with Parity Check

This block sits on the address and command path of a registered memory module. On every clock edge it captures a 28-bit command word and presents the captured value on two identical output copies. Each copy drives one half of the module's load. A controller-supplied parity bit travels with 22 of the word's bits. The block checks that pair against an odd-parity rule and reports a mismatch on an active-low flag. It also publishes the registered check result on its own output.

The word has a fixed layout. Bits 21:0 are the checked field, which carries address, bank and command bits. Bits 27:22 are control bits: two active-low rank selects at bits 23:22, then clock-enable and termination controls above them. When neither rank select is low, the checked field of both copies holds its value, so the heavily loaded outputs do not toggle. The control bits are always registered. Reset is synchronous and active-low.

Top module: `addr_cmd_fanout_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, both copies become 0, `par_out` becomes 0 and `err_n` becomes 1 after that edge. This also applies to a reset applied in mid-run.
- R2: `q_a` and `q_b` carry identical values in every cycle.
- R3: When at least one of `din[22]` or `din[23]` is 0 at a capture edge, all 28 bits of `din` appear on both copies right after that edge.
- R4: When `din[23:22]` is 2'b11 at a capture edge, bits 21:0 of both copies keep their previous values.
- R5: Bits 27:22 of both copies follow `din[27:22]` at every capture edge, whatever the rank selects are.
- R6: Right after the edge that captures `din[21:0]` and `par_in`, `par_out` is 1 exactly when those 23 bits contain an even number of ones. An odd count of ones is the correct parity.
- R7: For a single mismatched capture at edge e, `err_n` is still 1 after edge e. It is 0 after edges e+1 and e+2, and it returns to 1 after edge e+3 if no further mismatch occurs.
- R8: Mismatches on consecutive captures keep `err_n` low without a gap. It stays low until two edges after the `err_n` update for the last mismatch.
- R9: Parity is checked at every capture, including captures where both rank selects are 1 and the checked outputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 28 | Command word: [21:0] checked field, [23:22] rank selects (active low), [27:24] other controls |
| par_in | input | 1 | Odd-parity bit from the controller covering din[21:0] |
| q_a | output | 28 | Registered copy A |
| q_b | output | 28 | Registered copy B |
| par_out | output | 1 | Registered check result, 1 = mismatch |
| err_n | output | 1 | Stretched error flag, active low |

## Verification
Two situations are hard to reach from the ports: a parity mismatch on a deselected cycle, and a mismatch that overlaps the tail of a previous error. In the first, the outputs show nothing because the checked field is frozen. In the second, the stretch and the new error merge. The stimulus covers the first case by loading a known value and then driving a wrong parity bit together with both selects at 1. It covers the second by issuing two back-to-back bad captures. It then counts the exact cycles in which `err_n` is low after the last bad capture.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int unsigned AFC_WORD_W = 28;
  localparam int unsigned AFC_CHK_W  = 22;

  typedef enum logic {
    ERR_IDLE    = 1'b0,
    ERR_STRETCH = 1'b1
  } err_state_e;
endpackage

// File: rtl/afc_copy_bank.sv
module afc_copy_bank #(
  parameter int unsigned WORD_W = afc_pkg::AFC_WORD_W,
  parameter int unsigned CHK_W  = afc_pkg::AFC_CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  localparam int unsigned CTL_W = WORD_W - CHK_W;

  logic [CHK_W-1:0] lo_q;
  logic [CTL_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      hi_q <= d[WORD_W-1:CHK_W];
      if (gate_en) lo_q <= d[CHK_W-1:0];
    end
  end

  assign q = {hi_q, lo_q};

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> $stable(q[CHK_W-1:0])); // R4
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |=> q == $past(d)); // R3
  AST_CTL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q[WORD_W-1:CHK_W] == $past(d[WORD_W-1:CHK_W])); // R5
endmodule

// File: rtl/afc_parity_chk.sv
module afc_parity_chk #(
  parameter int unsigned CHK_W = afc_pkg::AFC_CHK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CHK_W-1:0] chk,
  input  logic             par_in,
  output logic             miss_q,
  output logic             err_n
);
  import afc_pkg::*;

  // Odd rule: checked bits plus parity bit must hold an odd count of ones.
  function automatic logic odd_miss(input logic [CHK_W-1:0] b, input logic p);
    return ~(^{b, p});
  endfunction

  logic       miss_w;
  err_state_e st_q;
  logic       err_n_q;

  assign miss_w = odd_miss(chk, par_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q  <= 1'b0;
      st_q    <= ERR_IDLE;
      err_n_q <= 1'b1;
    end else begin
      miss_q <= miss_w;
      if (miss_q) begin
        err_n_q <= 1'b0;
        st_q    <= ERR_STRETCH;
      end else if (st_q == ERR_STRETCH) begin
        err_n_q <= 1'b0;
        st_q    <= ERR_IDLE;
      end else begin
        err_n_q <= 1'b1;
      end
    end
  end

  assign err_n = err_n_q;

  AST_PAR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> miss_q == $past(($countones({chk, par_in}) & 1) == 0)); // R6
  AST_ERR_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |=> !err_n); // R7
  AST_ERR_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_q && st_q == ERR_IDLE) |=> ##1 !err_n); // R8
  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_q && st_q == ERR_IDLE) |=> err_n); // R7
endmodule

// File: rtl/addr_cmd_fanout_reg.sv
module addr_cmd_fanout_reg #(
  parameter int unsigned WORD_W = afc_pkg::AFC_WORD_W,
  parameter int unsigned CHK_W  = afc_pkg::AFC_CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              par_in,
  output logic [WORD_W-1:0] q_a,
  output logic [WORD_W-1:0] q_b,
  output logic              par_out,
  output logic              err_n
);
  localparam int unsigned NCOPY   = 2;
  localparam int unsigned SEL_POS = CHK_W;

  logic              gate_en;
  logic [WORD_W-1:0] q_cp [NCOPY];

  // Either active-low rank select low enables the checked field.
  assign gate_en = ~&din[SEL_POS+1:SEL_POS];

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    afc_copy_bank #(.WORD_W(WORD_W), .CHK_W(CHK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .d(din), .q(q_cp[c])
    );
  end

  assign q_a = q_cp[0];
  assign q_b = q_cp[1];

  afc_parity_chk #(.CHK_W(CHK_W)) u_par (
    .clk(clk), .rst_n(rst_n), .chk(din[CHK_W-1:0]), .par_in(par_in),
    .miss_q(par_out), .err_n(err_n)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (q_a == '0 && par_out == 1'b0 && err_n == 1'b1)); // R1
endmodule

// File: tb/sim_addr_cmd_fanout_reg.sv
module sim_addr_cmd_fanout_reg;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] din = '0;
  logic        par_in = 1'b0;
  logic [27:0] q_a, q_b;
  logic        par_out, err_n;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  addr_cmd_fanout_reg u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .par_in(par_in),
    .q_a(q_a), .q_b(q_b), .par_out(par_out), .err_n(err_n)
  );

  function automatic logic good_par(input logic [21:0] lo);
    int n = 0;
    for (int i = 0; i < 22; i++) if (lo[i]) n++;
    return (n % 2 == 0);
  endfunction

  function automatic logic [27:0] mk(input logic [3:0] hi, input logic [1:0] sel,
                                     input logic [21:0] lo);
    return {hi, sel, lo};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [27:0] d, input logic p);
    @(negedge clk);
    din = d;
    par_in = p;
    @(posedge clk);
    #1;
  endtask

  task automatic step_good(input logic [27:0] d);
    step(d, good_par(d[21:0]));
  endtask

  task automatic t_reset;
    rst_n = 0;
    step_good(mk(4'hF, 2'b00, 22'h2AAAAA));
    step_good(mk(4'hF, 2'b00, 22'h2AAAAA));
    check("R1 q_a", {4'h0, q_a}, 32'h0);
    check("R1 q_b", {4'h0, q_b}, 32'h0);
    check("R1 par_out", {31'h0, par_out}, 32'h0);
    check("R1 err_n", {31'h0, err_n}, 32'h1);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_load;
    logic [27:0] pats [3];
    pats[0] = mk(4'h5, 2'b10, 22'h3FFFFF);
    pats[1] = mk(4'hA, 2'b01, 22'h155555);
    pats[2] = mk(4'h3, 2'b00, 22'h000001);
    foreach (pats[i]) begin
      step_good(pats[i]);
      check("R3 q_a load", {4'h0, q_a}, {4'h0, pats[i]});
      check("R2 copies equal", {4'h0, q_b}, {4'h0, q_a});
      check("R6 good parity", {31'h0, par_out}, 32'h0);
    end
  endtask

  task automatic t_gate;
    logic [27:0] a, b, c;
    a = mk(4'h1, 2'b10, 22'h12345);
    b = mk(4'hE, 2'b11, 22'h3ABCDE);
    c = mk(4'h6, 2'b11, 22'h0F0F0F);
    step_good(a);
    step_good(b);
    check("R4 lo held", {10'h0, q_a[21:0]}, {10'h0, a[21:0]});
    check("R5 ctl follows", {26'h0, q_a[27:22]}, {26'h0, b[27:22]});
    check("R2 copies equal gated", {4'h0, q_b}, {4'h0, q_a});
    step_good(c);
    check("R4 lo held twice", {10'h0, q_b[21:0]}, {10'h0, a[21:0]});
    check("R5 ctl follows twice", {26'h0, q_b[27:22]}, {26'h0, c[27:22]});
  endtask

  task automatic t_single_err;
    logic [27:0] g;
    g = mk(4'h0, 2'b00, 22'h00F00F);
    step(g, ~good_par(g[21:0]));
    check("R6 miss flagged", {31'h0, par_out}, 32'h1);
    check("R7 err not yet", {31'h0, err_n}, 32'h1);
    step_good(g);
    check("R6 par_out clears", {31'h0, par_out}, 32'h0);
    check("R7 err low 1", {31'h0, err_n}, 32'h0);
    step_good(g);
    check("R7 err low 2", {31'h0, err_n}, 32'h0);
    step_good(g);
    check("R7 err released", {31'h0, err_n}, 32'h1);
  endtask

  task automatic t_back2back;
    logic [27:0] g;
    g = mk(4'h9, 2'b01, 22'h1C3C3C);
    step(g, ~good_par(g[21:0]));
    step(g, ~good_par(g[21:0]));
    check("R8 err low first", {31'h0, err_n}, 32'h0);
    step_good(g);
    check("R8 err low second", {31'h0, err_n}, 32'h0);
    step_good(g);
    check("R8 err low tail", {31'h0, err_n}, 32'h0);
    step_good(g);
    check("R8 err released", {31'h0, err_n}, 32'h1);
  endtask

  task automatic t_desel_parity;
    logic [27:0] a, b;
    a = mk(4'h2, 2'b00, 22'h111111);
    b = mk(4'h2, 2'b11, 22'h222222);
    step_good(a);
    step(b, ~good_par(b[21:0]));
    check("R9 miss while deselected", {31'h0, par_out}, 32'h1);
    check("R4 lo held during miss", {10'h0, q_a[21:0]}, {10'h0, a[21:0]});
    step_good(a);
    check("R9 err low after deselected miss", {31'h0, err_n}, 32'h0);
    step_good(a);
    step_good(a);
    check("R9 err released", {31'h0, err_n}, 32'h1);
  endtask

  task automatic t_mid_reset;
    logic [27:0] g;
    g = mk(4'hC, 2'b10, 22'h3F00FF);
    step(g, ~good_par(g[21:0]));
    check("R3 loaded before reset", {4'h0, q_a}, {4'h0, g});
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    #1;
    check("R1 mid q_a", {4'h0, q_a}, 32'h0);
    check("R1 mid q_b", {4'h0, q_b}, 32'h0);
    check("R1 mid par_out", {31'h0, par_out}, 32'h0);
    check("R1 mid err_n", {31'h0, err_n}, 32'h1);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_gate();
    t_single_err();
    t_back2back();
    t_desel_parity();
    t_mid_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule